// File: doc/BRIEF.md
# Fixed-Point Word-Length Advisor

This block observes one stream of signed two's-complement fixed-point samples and keeps running statistics that describe how much of the number format the stream really uses. From those statistics it derives a suggested fixed-point format: how many integer bits, how many fractional bits and what total width would represent the observed values without loss. It is meant to sit beside a datapath signal during characterisation runs, so that the word length of that signal can be chosen from measured data. A synchronous clear starts a fresh analysis without a full reset.

The statistics are the largest and smallest sample values, a sticky flag that records whether any negative sample occurred, the smallest nonzero sample magnitude, and the smallest nonzero step between two consecutive samples. The suggested integer-bit count comes from the largest magnitude. The suggested fractional-bit count is the larger of two candidates, one taken from the smallest magnitude and one from the smallest step. All base-2 logarithms are found from the leading-one position of the raw value, shifted by the fractional-bit count of the input format.

Control is a two-state machine. State `ST_EMPTY` means no sample has been taken since reset or clear. State `ST_RUN` means at least one sample is held as the previous sample. Transition `T_FIRST` (ST_EMPTY to ST_RUN) fires on a valid sample without clear. Transition `T_CLEAR` (any state to ST_EMPTY) fires on `clr`. In every other case the state is held.

Top module: `vrm_monitor`

## Requirements
- R1: After reset, or on the cycle after `clr` is high at a clock edge, every statistic and recommendation output is zero and both minimum-valid flags are low. When `clr` and `smp_vld` are high together, the sample is dropped.
- R2: The first valid sample after a clear sets both `stat_max` and `stat_min`. Each later sample raises `stat_max` or lowers `stat_min` when it lies beyond them.
- R3: `stat_signed` goes high on the first negative sample and then stays high until a clear.
- R4: `min_mag` holds the smallest nonzero absolute sample value seen, with `min_mag_vld` high once one exists. Zero samples leave both unchanged.
- R5: `min_step` holds the smallest nonzero absolute difference between consecutive valid samples, with `min_step_vld` high once one exists. The first sample after a clear gives no difference, and a repeated value leaves both unchanged.
- R6: `rec_int` equals ceil(log2(M)) plus 1 when `stat_signed` is high. M is the larger of |stat_max| and |stat_min|, scaled by 2^-FRAC_W. When M is zero the logarithm term is 0, and the value may be negative.
- R7: `rec_frac` is the larger of two candidates, each taken as -floor(log2(v)) and clamped at 0. v is `min_mag` or `min_step`, scaled by 2^-FRAC_W. A candidate whose valid flag is low counts as 0.
- R8: `rec_width` equals `rec_int` plus `rec_frac`.
- R9: The most negative input value (-2^(DATA_W-1)) is taken with its exact magnitude 2^(DATA_W-1), with no overflow.
- R10: Outputs are combinational from registered state, so a sample taken at one rising edge is fully reflected in every output before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, starts a new analysis |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Signed fixed-point sample, FRAC_W fractional bits |
| stat_max | output | DATA_W | Largest sample seen (signed) |
| stat_min | output | DATA_W | Smallest sample seen (signed) |
| stat_signed | output | 1 | A negative sample has been seen |
| min_mag | output | DATA_W | Smallest nonzero sample magnitude |
| min_mag_vld | output | 1 | `min_mag` holds a value |
| min_step | output | DATA_W+1 | Smallest nonzero consecutive-sample step |
| min_step_vld | output | 1 | `min_step` holds a value |
| rec_int | output | LOG_W | Suggested integer bits (signed) |
| rec_frac | output | LOG_W | Suggested fractional bits (unsigned) |
| rec_width | output | LOG_W | Suggested total width (signed) |

## Verification
On every cycle the assertions check that the sign flag is sticky and that a clear empties the machine. They also check that the two minima only decrease once valid, that a valid minimum is never zero, and that no step is recorded from the first sample after a clear. The log2 arithmetic and its exact-power-of-two edge can only be shown by the bench's scenarios, which compare every output on every clock against a behavioural model. The same holds for the clamping of fractional candidates, the handling of the most negative value, and the rule that a clear beats a same-cycle sample.

// File: rtl/vrm_pkg.sv
package vrm_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_RUN   = 1'b1
    } vrm_state_t;

endpackage

// File: rtl/vrm_abs.sv
module vrm_abs #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] x,
    output logic        [W-1:0] mag
);
    // Widen by one bit before negating so -2^(W-1) yields 2^(W-1) exactly.
    logic signed [W:0] ext;
    logic signed [W:0] neg;

    assign ext = {x[W-1], x};
    assign neg = -ext;
    assign mag = x[W-1] ? neg[W-1:0] : x[W-1:0];

endmodule

// File: rtl/vrm_log2.sv
module vrm_log2 #(
    parameter int W      = 16,
    parameter int FRAC_W = 8,
    parameter int LW     = 7
) (
    input  logic        [W-1:0]  val,
    output logic                 nz,
    output logic signed [LW-1:0] flog,
    output logic signed [LW-1:0] clog
);
    localparam int PW = $clog2(W + 1);

    logic [PW-1:0] lead;
    logic          pow2;

    // Highest set bit wins because later iterations overwrite earlier ones.
    always_comb begin
        lead = '0;
        for (int i = 0; i < W; i++) begin
            if (val[i]) lead = PW'(i);
        end
    end

    assign nz   = |val;
    assign pow2 = ((val & (val - W'(1))) == '0);

    always_comb begin
        if (nz) begin
            flog = $signed(LW'(lead) - LW'(FRAC_W));
        end else begin
            flog = '0;
        end
        if (nz && !pow2) begin
            clog = flog + LW'(1);
        end else begin
            clog = flog;
        end
    end

endmodule

// File: rtl/vrm_stats.sv
module vrm_stats
    import vrm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     smp_vld,
    input  logic signed [DATA_W-1:0] smp_data,
    output logic signed [DATA_W-1:0] max_q,
    output logic signed [DATA_W-1:0] min_q,
    output logic                     sgn_q,
    output logic        [DATA_W-1:0] mag_q,
    output logic                     mag_vld_q,
    output logic        [DATA_W:0]   step_q,
    output logic                     step_vld_q
);
    vrm_state_t state_q, state_d;

    logic signed [DATA_W-1:0] prev_q;
    logic        [DATA_W-1:0] cur_mag;
    logic signed [DATA_W:0]   diff;
    logic        [DATA_W:0]   cur_step;
    logic                     take;

    assign take = smp_vld && !clr;
    assign diff = {prev_q[DATA_W-1], prev_q} - {smp_data[DATA_W-1], smp_data};

    vrm_abs #(.W(DATA_W))     u_abs_smp  (.x(smp_data), .mag(cur_mag));
    vrm_abs #(.W(DATA_W + 1)) u_abs_step (.x(diff),     .mag(cur_step));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions: T_CLEAR dominates, T_FIRST on first accepted sample
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (clr) state_d = ST_EMPTY;
                      else if (smp_vld) state_d = ST_RUN;
            ST_RUN:   if (clr) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // Statistic registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_q      <= '0;
            min_q      <= '0;
            prev_q     <= '0;
            sgn_q      <= 1'b0;
            mag_q      <= '0;
            mag_vld_q  <= 1'b0;
            step_q     <= '0;
            step_vld_q <= 1'b0;
        end else if (clr) begin
            max_q      <= '0;
            min_q      <= '0;
            prev_q     <= '0;
            sgn_q      <= 1'b0;
            mag_q      <= '0;
            mag_vld_q  <= 1'b0;
            step_q     <= '0;
            step_vld_q <= 1'b0;
        end else if (take) begin
            prev_q <= smp_data;
            if (smp_data[DATA_W-1]) sgn_q <= 1'b1;
            if (cur_mag != '0 && (!mag_vld_q || cur_mag < mag_q)) begin
                mag_q     <= cur_mag;
                mag_vld_q <= 1'b1;
            end
            unique case (state_q)
                ST_EMPTY: begin
                    max_q <= smp_data;
                    min_q <= smp_data;
                end
                ST_RUN: begin
                    if (smp_data > max_q) max_q <= smp_data;
                    if (smp_data < min_q) min_q <= smp_data;
                    if (cur_step != '0 && (!step_vld_q || cur_step < step_q)) begin
                        step_q     <= cur_step;
                        step_vld_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    a_r3_sign_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sgn_q && !clr) |=> sgn_q);

    a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == ST_EMPTY && !sgn_q && !mag_vld_q && !step_vld_q));

    a_r4_mag_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (mag_vld_q && !clr) |=> (mag_vld_q && mag_q <= $past(mag_q)));

    a_r4_mag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        mag_vld_q |-> (mag_q != '0));

    a_r5_step_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (step_vld_q && !clr) |=> (step_vld_q && step_q <= $past(step_q)));

    a_r5_no_first_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && !clr) |=> !step_vld_q);

    a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (max_q >= min_q));

endmodule

// File: rtl/vrm_monitor.sv
module vrm_monitor #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8,
    parameter int LOG_W  = $clog2(2 * DATA_W + 4) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     smp_vld,
    input  logic signed [DATA_W-1:0] smp_data,
    output logic signed [DATA_W-1:0] stat_max,
    output logic signed [DATA_W-1:0] stat_min,
    output logic                     stat_signed,
    output logic        [DATA_W-1:0] min_mag,
    output logic                     min_mag_vld,
    output logic        [DATA_W:0]   min_step,
    output logic                     min_step_vld,
    output logic signed [LOG_W-1:0]  rec_int,
    output logic        [LOG_W-1:0]  rec_frac,
    output logic signed [LOG_W-1:0]  rec_width
);
    logic [DATA_W-1:0] hi_mag, lo_mag, big_mag;

    logic                    big_nz, mag_nz, step_nz;
    logic signed [LOG_W-1:0] big_flog, big_clog;
    logic signed [LOG_W-1:0] mag_flog, mag_clog;
    logic signed [LOG_W-1:0] step_flog, step_clog;
    logic signed [LOG_W-1:0] cand_mag, cand_step, frac_s;

    vrm_stats #(.DATA_W(DATA_W)) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .smp_vld    (smp_vld),
        .smp_data   (smp_data),
        .max_q      (stat_max),
        .min_q      (stat_min),
        .sgn_q      (stat_signed),
        .mag_q      (min_mag),
        .mag_vld_q  (min_mag_vld),
        .step_q     (min_step),
        .step_vld_q (min_step_vld)
    );

    vrm_abs #(.W(DATA_W)) u_abs_hi (.x(stat_max), .mag(hi_mag));
    vrm_abs #(.W(DATA_W)) u_abs_lo (.x(stat_min), .mag(lo_mag));

    assign big_mag = (hi_mag > lo_mag) ? hi_mag : lo_mag;

    vrm_log2 #(.W(DATA_W), .FRAC_W(FRAC_W), .LW(LOG_W)) u_log_big (
        .val(big_mag), .nz(big_nz), .flog(big_flog), .clog(big_clog));

    vrm_log2 #(.W(DATA_W), .FRAC_W(FRAC_W), .LW(LOG_W)) u_log_mag (
        .val(min_mag), .nz(mag_nz), .flog(mag_flog), .clog(mag_clog));

    vrm_log2 #(.W(DATA_W + 1), .FRAC_W(FRAC_W), .LW(LOG_W)) u_log_step (
        .val(min_step), .nz(step_nz), .flog(step_flog), .clog(step_clog));

    always_comb begin
        cand_mag  = '0;
        cand_step = '0;
        if (min_mag_vld && mag_nz && mag_flog < 0)
            cand_mag = -mag_flog;
        if (min_step_vld && step_nz && step_flog < 0)
            cand_step = -step_flog;
        frac_s = (cand_mag > cand_step) ? cand_mag : cand_step;
    end

    assign rec_int   = (big_nz ? big_clog : '0) + LOG_W'(stat_signed);
    assign rec_frac  = frac_s;
    assign rec_width = rec_int + frac_s;

    a_r7_frac_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        !frac_s[LOG_W-1]);

    a_r7_frac_zero_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!min_mag_vld && !min_step_vld) |-> (rec_frac == '0));

    // R6: the unused floor/ceil outputs are tied off in meaning only
    a_r6_ceil_ge_floor: assert property (@(posedge clk) disable iff (!rst_n)
        big_clog >= big_flog && mag_clog >= mag_flog && step_clog >= step_flog);

endmodule

// File: tb/vrm_monitor_test.sv
module vrm_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int FW = 8;
    localparam int LW = 7;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [DW-1:0] smp_data = '0;
    logic signed [DW-1:0] stat_max, stat_min;
    logic stat_signed, min_mag_vld, min_step_vld;
    logic [DW-1:0] min_mag;
    logic [DW:0] min_step;
    logic signed [LW-1:0] rec_int, rec_width;
    logic [LW-1:0] rec_frac;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_max, m_min, m_mag, m_step, m_prev;
    bit m_sgn, m_have;

    always #(CLK_PERIOD/2) clk = ~clk;

    vrm_monitor #(.DATA_W(DW), .FRAC_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld), .smp_data(smp_data),
        .stat_max(stat_max), .stat_min(stat_min), .stat_signed(stat_signed),
        .min_mag(min_mag), .min_mag_vld(min_mag_vld),
        .min_step(min_step), .min_step_vld(min_step_vld),
        .rec_int(rec_int), .rec_frac(rec_frac), .rec_width(rec_width)
    );

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int flog2(int v);
        int p = 0;
        for (int i = 0; i < 31; i++) if ((v >> i) & 1) p = i;
        return p - FW;
    endfunction

    function automatic int clog2x(int v);
        return ((v & (v - 1)) == 0) ? flog2(v) : flog2(v) + 1;
    endfunction

    function automatic int e_int();
        int big = (iabs(m_max) > iabs(m_min)) ? iabs(m_max) : iabs(m_min);
        return ((big == 0) ? 0 : clog2x(big)) + (m_sgn ? 1 : 0);
    endfunction

    function automatic int e_frac();
        int a = 0;
        int b = 0;
        if (m_mag != 0 && -flog2(m_mag) > 0) a = -flog2(m_mag);
        if (m_step != 0 && -flog2(m_step) > 0) b = -flog2(m_step);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_max = 0; m_min = 0; m_mag = 0; m_step = 0; m_prev = 0;
        m_sgn = 0; m_have = 0;
    endtask

    task automatic model_take(int x);
        int d;
        if (x < 0) m_sgn = 1;
        if (x != 0 && (m_mag == 0 || iabs(x) < m_mag)) m_mag = iabs(x);
        if (!m_have) begin
            m_max = x; m_min = x;
        end else begin
            if (x > m_max) m_max = x;
            if (x < m_min) m_min = x;
            d = iabs(x - m_prev);
            if (d != 0 && (m_step == 0 || d < m_step)) m_step = d;
        end
        m_prev = x;
        m_have = 1;
    endtask

    // Every output compared against the model (R10: one edge after the sample)
    task automatic compare_all();
        chk("R2 max", int'(stat_max), m_max);
        chk("R2 min", int'(stat_min), m_min);
        chk("R3 signed", int'(stat_signed), int'(m_sgn));
        chk("R4 min_mag", int'(min_mag), m_mag);
        chk("R4 min_mag_vld", int'(min_mag_vld), (m_mag != 0) ? 1 : 0);
        chk("R5 min_step", int'(min_step), m_step);
        chk("R5 min_step_vld", int'(min_step_vld), (m_step != 0) ? 1 : 0);
        chk("R6 rec_int", int'(rec_int), e_int());
        chk("R7 rec_frac", int'(rec_frac), e_frac());
        chk("R8 rec_width", int'(rec_width), e_int() + e_frac());
    endtask

    task automatic cyc(bit v, bit c, int x);
        smp_vld = v; clr = c; smp_data = DW'(x);
        @(posedge clk);
        if (c) model_clear();
        else if (v) model_take(x);
        @(negedge clk);
        smp_vld = 0; clr = 0;
        compare_all();
    endtask

    task automatic check_empty(string tag);
        chk({tag, " max"}, int'(stat_max), 0);
        chk({tag, " min"}, int'(stat_min), 0);
        chk({tag, " signed"}, int'(stat_signed), 0);
        chk({tag, " mag_vld"}, int'(min_mag_vld), 0);
        chk({tag, " step_vld"}, int'(min_step_vld), 0);
        chk({tag, " width"}, int'(rec_width), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        model_clear();
        repeat (3) @(negedge clk);
        check_empty("R1 reset");
        rst_n = 1;
        @(negedge clk);
        check_empty("R1 after reset");

        // zero samples only: no minima, R4 zero ignored, R5 repeat ignored
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        chk("R4 zero leaves mag invalid", int'(min_mag_vld), 0);
        chk("R5 repeat leaves step invalid", int'(min_step_vld), 0);

        cyc(0, 1, 0);
        check_empty("R1 clear");

        // first sample: no step (R5), sets max and min (R2)
        cyc(1, 0, 384);        // 1.5
        chk("R5 first sample no step", int'(min_step_vld), 0);
        chk("R10 max visible next edge", int'(stat_max), 384);
        chk("R6 int for 1.5", int'(rec_int), 1);
        cyc(1, 0, 384);
        chk("R5 equal samples no step", int'(min_step_vld), 0);
        cyc(1, 0, 64);         // 0.25, step 320
        chk("R7 frac for 0.25", int'(rec_frac), 2);
        cyc(1, 0, 66);         // step 2 -> 2^-7
        chk("R7 frac from step", int'(rec_frac), 7);
        cyc(0, 0, 12345);      // invalid, ignored
        cyc(1, 0, 512);        // exact power of two 2.0
        chk("R6 int for exact 2.0", int'(rec_int), 1);
        cyc(1, 0, -768);
        chk("R3 signed set", int'(stat_signed), 1);
        cyc(1, 0, 100);
        chk("R3 signed sticky", int'(stat_signed), 1);
        cyc(1, 0, -32768);
        chk("R9 most negative magnitude int", int'(rec_int), 8);
        chk("R9 min value", int'(stat_min), -32768);

        // clear with a simultaneous sample: sample dropped
        cyc(1, 1, 777);
        check_empty("R1 clear beats sample");

        // small values: negative integer bits
        cyc(1, 0, 3);
        chk("R6 negative int bits", int'(rec_int), -6);
        cyc(1, 0, 1);
        chk("R7 frac at lsb", int'(rec_frac), 8);
        chk("R8 width small", int'(rec_width), 2);

        // pseudo-random stream with occasional clears, zeros and repeats
        seed = 12345;
        for (int n = 0; n < 400; n++) begin
            int x;
            seed = seed * 1103515245 + 12345;
            x = (seed >>> 8) % 32768;
            if ((n % 7) == 3) x = 0;
            if ((n % 11) == 5) x = m_prev;
            if ((n % 5) == 1) x = x >>> ((n % 13));
            if ((n % 97) == 50) cyc(0, 1, 0);
            else cyc(((n % 9) != 8), 0, x);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule